// File: doc/BRIEF.md
# Interleaved Flash Instruction Fetch Unit

This block serves instruction fetch requests from a flash array organised as a pair of 128-bit banks that are read side by side. The CPU may ask for any byte address. The unit drops the five low address bits to find the enclosing 256-bit line, reads one 128-bit word from each bank in parallel and returns the whole line. It also returns the byte offset of the requested instruction inside that line, so the CPU can pick out instructions that straddle no particular boundary.

The last line fetched is held in a one-line buffer. A request that lands in the same line is answered from the buffer after one cycle and does not touch the banks. A miss waits for a programmable number of wait states before the response appears. A separate programming port writes 64-bit words into the array and refuses any address that is not on a 64-bit boundary. Because the buffer is not updated by programming, software pulses the invalidate input after it writes to the array.

Top module: `flash_fetch_unit`

## Requirements
- R1: After reset req_ready is 1, rsp_valid and prog_err are 0, the line buffer is empty, and every array bit reads as 1 (erased).
- R2: A fetch of byte address A returns the 256-bit line that starts at A with bits [4:0] cleared, and rsp_offset equals A[4:0].
- R3: Array layout: rsp_line[127:0] comes from bank 0 and rsp_line[255:128] from bank 1. A programming address selects bank 1 when bit 4 is 1, the upper 64-bit half of the 128-bit bank word when bit 3 is 1, and the word index from bits [ADDR_W-1:5].
- R4: A request whose line matches the valid buffered line is a hit: rsp_valid rises one cycle after acceptance, with the buffered data and no bank read, so data programmed since the fill is not seen.
- R5: A miss raises rsp_valid ws_cfg+2 cycles after acceptance (ws_cfg from 0 to 15) and refills the buffer with the fetched line.
- R6: rsp_valid lasts exactly one cycle, and req_ready is 0 from the cycle after acceptance through the response cycle.
- R7: A programming request with prog_addr[2:0] equal to 0 writes prog_data into the array and leaves prog_err at 0. Any other address raises prog_err for one cycle in the next cycle and changes nothing.
- R8: A pulse on inval empties the line buffer, so the next fetch is a miss and reads the current array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_cfg | input | WS_W | Wait states added to a miss |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Unit can accept a fetch request |
| req_addr | input | ADDR_W | Requested byte address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_line | output | 256 | Fetched line, bank 1 above bank 0 |
| rsp_offset | output | 5 | Byte offset of the request in the line |
| inval | input | 1 | Empty the line buffer |
| prog_valid | input | 1 | Programming request |
| prog_addr | input | ADDR_W | Programming byte address |
| prog_data | input | 64 | Programming data |
| prog_err | output | 1 | Misaligned programming request rejected |

## Verification
Fetches go to every offset of a line and to lines on either side, which separates correct line alignment from an offset-only or unmasked address. Programming distinct patterns into each bank and each 64-bit half shows whether the two halves of the line are swapped or mis-indexed. Back-to-back fetches of one line, fetches after programming with and without an invalidate, and wait-state settings of 0, 15 and random values tell a hit from a miss by latency and by stale versus fresh data. Misaligned programming addresses at every nonzero low-bit value, followed by a fetch of the target line, show that a rejected write leaves the array alone.

// File: rtl/ffu_pkg.sv
package ffu_pkg;
    localparam int BANK_W = 128;
    localparam int NBANKS = 2;
    localparam int LINE_W = NBANKS * BANK_W;
    localparam int OFF_W  = 5;
    localparam int PROG_W = 64;
    localparam int PROG_ALIGN_BITS = 3;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_RESP = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic [OFF_W-1:0]  off;
        logic [LINE_W-1:0] line;
    } fetch_rsp_t;

    function automatic logic prog_misaligned(input logic [PROG_ALIGN_BITS-1:0] low);
        return low != '0;
    endfunction
endpackage

// File: rtl/ffu_bank.sv
module ffu_bank
    import ffu_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BANK_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_upper,
    input  logic [PROG_W-1:0] wr_data
);
    localparam int WORDS = 1 << IDX_W;

    logic [BANK_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (wr_en) begin
            if (wr_upper) mem[wr_idx][BANK_W-1:PROG_W] <= wr_data;
            else          mem[wr_idx][PROG_W-1:0]      <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/ffu_line_buf.sv
module ffu_line_buf
    import ffu_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inval,
    input  logic              fill,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [TAG_W-1:0]  look_tag,
    output logic              hit,
    output logic [LINE_W-1:0] buf_line
);
    logic              vld_q;
    logic [TAG_W-1:0]  tag_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (rst || inval) begin
            vld_q <= 1'b0;
        end else if (fill) begin
            vld_q <= 1'b1;
        end
        if (rst) begin
            tag_q  <= '0;
            line_q <= '0;
        end else if (fill) begin
            tag_q  <= fill_tag;
            line_q <= fill_line;
        end
    end

    assign hit      = vld_q && (tag_q == look_tag);
    assign buf_line = line_q;
endmodule

// File: rtl/ffu_wait_ctr.sv
module ffu_wait_ctr #(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [WS_W-1:0] load_val,
    input  logic            run,
    output logic            done
);
    logic [WS_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/flash_fetch_unit.sv
module flash_fetch_unit
    import ffu_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int WS_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WS_W-1:0]   ws_cfg,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [255:0]      rsp_line,
    output logic [4:0]        rsp_offset,
    input  logic              inval,
    input  logic              prog_valid,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [63:0]       prog_data,
    output logic              prog_err
);
    localparam int TAG_W = ADDR_W - OFF_W;

    fetch_state_e      state_q;
    logic [TAG_W-1:0]  tag_q;
    fetch_rsp_t        rsp_q;
    logic              err_q;

    logic              accept;
    logic              buf_hit;
    logic [LINE_W-1:0] buf_line;
    logic [LINE_W-1:0] array_line;
    logic              ctr_done;
    logic              fill;
    logic              prog_ok;
    logic [TAG_W-1:0]  look_tag;

    assign req_ready = (state_q == FS_IDLE);
    assign accept    = req_valid && req_ready;
    assign look_tag  = req_addr[ADDR_W-1:OFF_W];
    assign fill      = (state_q == FS_WAIT) && ctr_done;
    assign prog_ok   = prog_valid && !prog_misaligned(prog_addr[PROG_ALIGN_BITS-1:0]);

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic [BANK_W-1:0] rd_word;
        ffu_bank #(.IDX_W(TAG_W)) i_bank (
            .clk      (clk),
            .rst      (rst),
            .rd_idx   (tag_q),
            .rd_data  (rd_word),
            .wr_en    (prog_ok && (prog_addr[OFF_W-1] == 1'(b))),
            .wr_idx   (prog_addr[ADDR_W-1:OFF_W]),
            .wr_upper (prog_addr[PROG_ALIGN_BITS]),
            .wr_data  (prog_data)
        );
        assign array_line[b*BANK_W +: BANK_W] = rd_word;
    end

    ffu_line_buf #(.TAG_W(TAG_W)) i_buf (
        .clk       (clk),
        .rst       (rst),
        .inval     (inval),
        .fill      (fill),
        .fill_tag  (tag_q),
        .fill_line (array_line),
        .look_tag  (look_tag),
        .hit       (buf_hit),
        .buf_line  (buf_line)
    );

    ffu_wait_ctr #(.WS_W(WS_W)) i_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && !buf_hit),
        .load_val (ws_cfg),
        .run      (state_q == FS_WAIT),
        .done     (ctr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            tag_q   <= '0;
            rsp_q   <= '0;
        end else begin
            unique case (state_q)
                FS_IDLE: if (accept) begin
                    tag_q     <= look_tag;
                    rsp_q.off <= req_addr[OFF_W-1:0];
                    if (buf_hit) begin
                        rsp_q.line <= buf_line;
                        state_q    <= FS_RESP;
                    end else begin
                        state_q    <= FS_WAIT;
                    end
                end
                FS_WAIT: if (ctr_done) begin
                    rsp_q.line <= array_line;
                    state_q    <= FS_RESP;
                end
                FS_RESP: state_q <= FS_IDLE;
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= prog_valid && prog_misaligned(prog_addr[PROG_ALIGN_BITS-1:0]);
    end

    assign rsp_valid  = (state_q == FS_RESP);
    assign rsp_line   = rsp_q.line;
    assign rsp_offset = rsp_q.off;
    assign prog_err   = err_q;
endmodule

// File: rtl/ffu_checker.sv
module ffu_checker #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              prog_valid,
    input logic [ADDR_W-1:0] prog_addr,
    input logic              prog_err
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !rsp_valid && !prog_err));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    no_ready_in_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        prog_err |-> ($past(prog_valid) && ($past(prog_addr[2:0]) != 3'b000)));

    // R7
    aligned_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_valid && prog_addr[2:0] == 3'b000) |=> !prog_err);
endmodule

bind flash_fetch_unit ffu_checker #(.ADDR_W(ADDR_W)) i_ffu_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .prog_valid (prog_valid),
    .prog_addr  (prog_addr),
    .prog_err   (prog_err)
);

// File: tb/test_flash_fetch_unit.sv
module test_flash_fetch_unit;
    localparam int ADDR_W = 9;
    localparam int WS_W   = 4;
    localparam int LINES  = 1 << (ADDR_W - 5);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [WS_W-1:0]   ws_cfg = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [255:0]      rsp_line;
    logic [4:0]        rsp_offset;
    logic              inval = 1'b0;
    logic              prog_valid = 1'b0;
    logic [ADDR_W-1:0] prog_addr = '0;
    logic [63:0]       prog_data = '0;
    logic              prog_err;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // bench model of the array and of the line buffer
    logic [127:0] m_mem [2][LINES];
    bit           b_vld = 0;
    logic [3:0]   b_tag = '0;
    logic [255:0] b_line = '0;

    always #2 clk = ~clk;

    flash_fetch_unit #(.ADDR_W(ADDR_W), .WS_W(WS_W)) i_flash_fetch_unit (
        .clk(clk), .rst(rst), .ws_cfg(ws_cfg),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_line(rsp_line), .rsp_offset(rsp_offset),
        .inval(inval), .prog_valid(prog_valid), .prog_addr(prog_addr),
        .prog_data(prog_data), .prog_err(prog_err)
    );

    function automatic logic [255:0] model_line(input logic [3:0] idx);
        return {m_mem[1][idx], m_mem[0][idx]};
    endfunction

    function automatic int model_latency(input bit hit, input logic [WS_W-1:0] ws);
        return hit ? 1 : int'(ws) + 2;
    endfunction

    task automatic check(input string req, input string what, input logic [255:0] got,
                         input logic [255:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    task automatic do_fetch(input logic [ADDR_W-1:0] addr, input string req);
        logic [3:0]   tag;
        bit           hit;
        logic [255:0] exp_line;
        int           lat;
        tag      = addr[ADDR_W-1:5];
        hit      = b_vld && (b_tag == tag);
        exp_line = hit ? b_line : model_line(tag);
        @(negedge clk);
        check("R6", "ready before request", 256'(req_ready), 256'(1));
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(hit ? "R4" : "R5", "latency", 256'(lat), 256'(model_latency(hit, ws_cfg)));
        check(req, "line", rsp_line, exp_line);
        check("R2", "offset", 256'(rsp_offset), 256'(addr[4:0]));
        check("R6", "ready in response", 256'(req_ready), 256'(0));
        @(negedge clk);
        check("R6", "strobe length", 256'(rsp_valid), 256'(0));
        if (!hit) begin
            b_vld  = 1;
            b_tag  = tag;
            b_line = exp_line;
        end
    endtask

    task automatic do_prog(input logic [ADDR_W-1:0] addr, input logic [63:0] data);
        bit bad;
        bad = (addr[2:0] != 3'b000);
        @(negedge clk);
        prog_valid = 1'b1;
        prog_addr  = addr;
        prog_data  = data;
        @(negedge clk);
        prog_valid = 1'b0;
        check("R7", "prog_err", 256'(prog_err), 256'(bad));
        if (!bad) begin
            if (addr[3]) m_mem[addr[4]][addr[ADDR_W-1:5]][127:64] = data;
            else         m_mem[addr[4]][addr[ADDR_W-1:5]][63:0]   = data;
        end
    endtask

    task automatic do_inval();
        @(negedge clk);
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        b_vld = 0;
    endtask

    initial begin
        #800000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < LINES; i++) m_mem[b][i] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1", "ready", 256'(req_ready), 256'(1));
        check("R1", "rsp_valid", 256'(rsp_valid), 256'(0));
        check("R1", "prog_err", 256'(prog_err), 256'(0));
        ws_cfg = 4'd2;
        do_fetch(9'h000, "R1");

        // R3 distinct patterns in each bank and half of line 3
        do_prog(9'h060, 64'h0000_0000_AAAA_0001);
        do_prog(9'h068, 64'h0000_0000_AAAA_0002);
        do_prog(9'h070, 64'h0000_0000_BBBB_0003);
        do_prog(9'h078, 64'h0000_0000_BBBB_0004);
        ws_cfg = 4'd3;
        do_fetch(9'h07B, "R3");
        do_fetch(9'h060, "R4");
        for (int o = 0; o < 32; o += 7) do_fetch(9'(9'h060 + o), "R2");

        // R4 stale data after programming without invalidate
        do_prog(9'h068, 64'h1234_5678_9ABC_DEF0);
        do_fetch(9'h065, "R4");
        // R8 invalidate exposes new contents
        do_inval();
        do_fetch(9'h065, "R8");

        // R7 every misaligned low-bit value is rejected
        for (int k = 1; k < 8; k++) do_prog(9'(9'h0A0 + k), 64'h0);
        do_inval();
        do_fetch(9'h0A0, "R7");

        // R5 wait-state extremes
        ws_cfg = 4'd0;
        do_fetch(9'h1E0, "R5");
        ws_cfg = 4'd15;
        do_fetch(9'h020, "R5");
        do_fetch(9'h1FF, "R2");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 4) begin
                logic [ADDR_W-1:0] a;
                a = 9'($urandom);
                if ($urandom_range(0, 3) != 0) a[2:0] = 3'b000;
                do_prog(a, {$urandom, $urandom});
            end else if (op < 9) begin
                ws_cfg = 4'($urandom);
                do_fetch(9'($urandom), "R2");
            end else begin
                do_inval();
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule